// File: doc/BRIEF.md
# USB Device Interrupt Collector

This block gathers every interrupt cause of a USB device controller with four IN and four OUT endpoints and turns them into a single interrupt line for the CPU. Each endpoint keeps a status register of sticky event bits and a mask of its own. When an event lands on a status bit that the endpoint mask leaves open, the endpoint's summary bit is raised in a shared 32-bit endpoint interrupt register. IN endpoints use the low half of that register and OUT endpoints use the high half. Bus-level events such as reset, suspend and start of frame are latched into a separate 8-bit device interrupt register.

Each summary register has its own mask, so masking works at two levels. A cause reaches the interrupt line only if its summary bit is pending and its summary mask bit is 0. All status registers clear by writing one to a bit. Software services an interrupt by reading the summary, walking the endpoints it names, and writing back the bits it has handled. Detection of events on the bus sits upstream, and each event arrives as a one-cycle pulse.

Top module: `usb_irq_collector`

## Requirements
- R1: After reset, every endpoint status, the endpoint interrupt register and the device interrupt register read 0. Every endpoint mask reads 0. The endpoint interrupt mask reads 32'hFFFF_FFFF and the device interrupt mask reads 8'hFF. `irq` is 0.
- R2: Endpoint event input bit j (0..6) sets bit 4+j of that endpoint's status at the next clock edge, and the bit stays set. The event bits are: 4 OUT data received, 5 SETUP received, 6 IN token, 7 no buffer, 8 buffer error, 9 bus or host error, 10 transmit DMA done. Status bits 0..3 and 11..31 read 0.
- R3: A write to a status register (an endpoint status, the endpoint interrupt register or the device interrupt register) clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R4: If a new event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: An event on IN endpoint i sets endpoint interrupt bit i, and an event on OUT endpoint i sets bit 16+i. This happens only when at least one of the event's bits has endpoint mask bit 0, judged by the mask before any write in that cycle. A masked event sets the status bit but not the summary bit. Endpoint interrupt bits 4..15 and 20..31 read 0.
- R6: Device event input bit n sets device interrupt bit n at the next edge, and the bit is sticky. The bits are: 0 configuration set, 1 interface set, 2 early suspend (bus idle for 3 ms), 3 bus reset, 4 suspend, 5 start of frame, 6 speed enumeration done, 7 device status changed.
- R7: `irq` is 1 exactly when (endpoint interrupt AND NOT its mask) or (device interrupt AND NOT its mask) is nonzero. It follows register state without any extra delay.
- R8: The address map is as follows.
  - When addr[4] is 1, the register belongs to an endpoint: addr[3] selects the direction (0 IN, 1 OUT), addr[2] selects status (0) or mask (1), and addr[1:0] gives the endpoint number. An endpoint mask holds bits 4..10 and reads 0 elsewhere.
  - When addr[4] is 0, addr[1:0] selects the register: 0 endpoint interrupt, 1 its mask (all 32 bits writable), 2 device interrupt, 3 device mask. addr[3:2] are ignored.
  - Mask writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ev | input | 28 | IN endpoint event pulses, 7 per endpoint, endpoint e at bits 7e+6..7e |
| out_ev | input | 28 | OUT endpoint event pulses, same layout |
| dev_ev | input | 8 | Device event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data (ones clear for status registers) |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Events and writes presented before a clock edge change the status, summary and mask registers at that edge. Reads and `irq` are combinational from those registers, so each result is due one edge after its stimulus. The bench drives inputs just after an edge, updates its reference model with the inputs that were present at the next edge, and samples `rd_data` and `irq` one time unit after that edge. A cause that sits in the same cycle as a clear or a mask write is therefore judged against the pre-edge state, exactly as R4 and R5 define it.

// File: rtl/usb_irq_collector.sv
module usb_irq_collector #(
  parameter int NEP    = 4,
  parameter int EV_W   = 7,
  parameter int EV_LSB = 4,
  parameter int DEV_W  = 8,
  parameter int ADDR_W = ((NEP > 1) ? $clog2(NEP) : 1) + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NEP*EV_W-1:0]   in_ev,
  input  logic [NEP*EV_W-1:0]   out_ev,
  input  logic [DEV_W-1:0]      dev_ev,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [31:0]           rd_data,
  output logic                  irq
);
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1;
  localparam int NK  = 2 * NEP;
  localparam int TOP = ADDR_W - 1;
  localparam int OUT_BASE = 16;

  logic [NK*EV_W-1:0]         ev_all;
  logic [NK-1:0][EV_W-1:0]    st_q, mk_q;
  logic [NK-1:0]              sum_q, sum_set, sum_clr, hit_st, hit_mk;
  logic [31:0]                epm_q, ep_int_q;
  logic [DEV_W-1:0]           dev_q, devm_q;
  logic                       wr_sum, wr_epm, wr_dev, wr_devm;
  logic                       any_ev;

  assign ev_all  = {out_ev, in_ev};
  assign any_ev  = |ev_all;
  assign wr_sum  = wr_en && !wr_addr[TOP] && (wr_addr[1:0] == 2'd0);
  assign wr_epm  = wr_en && !wr_addr[TOP] && (wr_addr[1:0] == 2'd1);
  assign wr_dev  = wr_en && !wr_addr[TOP] && (wr_addr[1:0] == 2'd2);
  assign wr_devm = wr_en && !wr_addr[TOP] && (wr_addr[1:0] == 2'd3);

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      hit_st[k]  = wr_en && wr_addr[TOP] && !wr_addr[TOP-2] &&
                   (wr_addr[TOP-1] == (k >= NEP)) && (wr_addr[EPW-1:0] == EPW'(k % NEP));
      hit_mk[k]  = wr_en && wr_addr[TOP] && wr_addr[TOP-2] &&
                   (wr_addr[TOP-1] == (k >= NEP)) && (wr_addr[EPW-1:0] == EPW'(k % NEP));
      sum_set[k] = |(ev_all[k*EV_W +: EV_W] & ~mk_q[k]);
      sum_clr[k] = wr_sum && wr_data[(k / NEP) * OUT_BASE + (k % NEP)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mk_q   <= '0;
      sum_q  <= '0;
      epm_q  <= '1;
      dev_q  <= '0;
      devm_q <= '1;
    end else begin
      for (int k = 0; k < NK; k++) begin
        st_q[k]  <= (st_q[k] & ~(hit_st[k] ? wr_data[EV_LSB +: EV_W] : '0)) | ev_all[k*EV_W +: EV_W];
        if (hit_mk[k]) mk_q[k] <= wr_data[EV_LSB +: EV_W];
        sum_q[k] <= (sum_q[k] & ~sum_clr[k]) | sum_set[k];
      end
      if (wr_epm) epm_q <= wr_data;
      dev_q <= (dev_q & ~(wr_dev ? wr_data[DEV_W-1:0] : '0)) | dev_ev;
      if (wr_devm) devm_q <= wr_data[DEV_W-1:0];
    end
  end

  always_comb begin
    ep_int_q = '0;
    for (int k = 0; k < NK; k++)
      ep_int_q[(k / NEP) * OUT_BASE + (k % NEP)] = sum_q[k];
  end

  assign irq = (|(ep_int_q & ~epm_q)) | (|(dev_q & ~devm_q));

  always_comb begin
    int rk;
    rd_data = '0;
    rk = (rd_addr[TOP-1] ? NEP : 0) + int'(rd_addr[EPW-1:0]);
    if (rd_addr[TOP]) begin
      if (rk < NK) begin
        if (rd_addr[TOP-2]) rd_data[EV_LSB +: EV_W] = mk_q[rk];
        else                rd_data[EV_LSB +: EV_W] = st_q[rk];
      end
    end else begin
      case (rd_addr[1:0])
        2'd0: rd_data = ep_int_q;
        2'd1: rd_data = epm_q;
        2'd2: rd_data[DEV_W-1:0] = dev_q;
        default: rd_data[DEV_W-1:0] = devm_q;
      endcase
    end
  end
endmodule

// File: rtl/usb_irq_collector_chk.sv
module usb_irq_collector_chk #(
  parameter int DEV_W  = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_ev,
  input logic [DEV_W-1:0]  dev_ev,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [DEV_W-1:0]  dev_q,
  input logic [31:0]       ep_int_q,
  input logic              irq
);
  logic dev_wr;
  assign dev_wr = wr_en && !wr_addr[ADDR_W-1] && (wr_addr[1:0] == 2'd2);

  p_dev_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ev != '0) |=> ((dev_q & $past(dev_ev)) == $past(dev_ev)));

  p_dev_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_wr |=> ((dev_q & $past(dev_q)) == $past(dev_q)));

  p_dev_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && dev_ev == '0) |=> ((dev_q & $past(wr_data[DEV_W-1:0])) == '0));

  p_summary_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_int_q & ~$past(ep_int_q)) != '0) |-> $past(any_ev));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_ev || dev_ev != '0 || wr_en));
endmodule

bind usb_irq_collector usb_irq_collector_chk #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .any_ev(any_ev), .dev_ev(dev_ev), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .dev_q(dev_q), .ep_int_q(ep_int_q), .irq(irq)
);

// File: tb/usb_irq_collector_test.sv
module usb_irq_collector_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] in_ev = '0, out_ev = '0;
  logic [7:0]  dev_ev = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [6:0]  mst [2][4];
  logic [6:0]  mmk [2][4];
  logic [3:0]  msum [2];
  logic [31:0] mepm;
  logic [7:0]  mdev, mdevm;

  usb_irq_collector uut (
    .clk(clk), .rst_n(rst_n), .in_ev(in_ev), .out_ev(out_ev), .dev_ev(dev_ev),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, rd_addr, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      msum[d] = '0;
      for (int e = 0; e < 4; e++) begin mst[d][e] = '0; mmk[d][e] = '0; end
    end
    mepm = '1; mdev = '0; mdevm = '1;
  endtask

  task automatic model_step();
    logic [6:0] ev;
    logic       set;
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < 4; e++) begin
        ev  = d ? out_ev[e*7 +: 7] : in_ev[e*7 +: 7];
        set = |(ev & ~mmk[d][e]);
        if (wr_en && wr_addr == {1'b1, d[0], 1'b0, e[1:0]}) mst[d][e] &= ~wr_data[10:4];
        mst[d][e] |= ev;
        if (wr_en && wr_addr == {1'b1, d[0], 1'b1, e[1:0]}) mmk[d][e] = wr_data[10:4];
        if (wr_en && !wr_addr[4] && wr_addr[1:0] == 2'd0 && wr_data[d*16 + e]) msum[d][e] = 1'b0;
        if (set) msum[d][e] = 1'b1;
      end
    if (wr_en && !wr_addr[4] && wr_addr[1:0] == 2'd1) mepm = wr_data;
    if (wr_en && !wr_addr[4] && wr_addr[1:0] == 2'd2) mdev &= ~wr_data[7:0];
    mdev |= dev_ev;
    if (wr_en && !wr_addr[4] && wr_addr[1:0] == 2'd3) mdevm = wr_data[7:0];
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    if (a[4]) return a[2] ? {21'd0, mmk[a[3]][a[1:0]], 4'd0} : {21'd0, mst[a[3]][a[1:0]], 4'd0};
    case (a[1:0])
      2'd0: return {12'd0, msum[1], 12'd0, msum[0]};
      2'd1: return mepm;
      2'd2: return {24'd0, mdev};
      default: return {24'd0, mdevm};
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(msum[0] & ~mepm[3:0])) | (|(msum[1] & ~mepm[19:16])) | (|(mdev & ~mdevm));
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a[4]) return a[2] ? "R8" : "R2/R3/R4";
    case (a[1:0])
      2'd0: return "R5/R3";
      2'd2: return "R6/R3";
      default: return "R8";
    endcase
  endfunction

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    #1;
    chk(rd_data, exp_rd(rd_addr), tag);
    chk({31'd0, irq}, {31'd0, exp_irq()}, "R7");
    in_ev = '0; out_ev = '0; dev_ev = '0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    #(CLK_P * 3 + 2);
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a); #1;
      chk(rd_data, exp_rd(rd_addr), "R1");
    end
    chk({31'd0, irq}, 32'd0, "R1");
    rst_n = 1'b1;
    #(CLK_P);

    // R4: clear and new event on IN endpoint 1, bit 5 (SETUP)
    in_ev[1*7 + 1] = 1'b1; cycle("R2");
    rd_addr = 5'b10001; wr(5'b10001, 32'hFFFF_FFFF); in_ev[1*7 + 1] = 1'b1; cycle("R4");
    chk(rd_data, 32'h20, "R4");
    // R5: masked event on OUT endpoint 2 does not raise the summary
    wr(5'b11110, 32'h0000_0400); cycle("R8");
    rd_addr = 5'b00000; out_ev[2*7 + 6] = 1'b1; cycle("R5");
    chk(rd_data, 32'h0000_0002, "R5");
    rd_addr = 5'b11010; cycle("R2");
    chk(rd_data, 32'h400, "R2");
    // R7: unmask summary bit 1 raises irq
    wr(5'b00001, 32'hFFFF_FFFD); cycle("R7");
    chk({31'd0, irq}, 32'd1, "R7");
    // R6: device bus reset event (bit 3), unmasked, clears after W1C
    rd_addr = 5'b00010; dev_ev = 8'h08; wr(5'b00011, 32'hFFFF_FFF7); cycle("R6");
    chk(rd_data, 32'h08, "R6");
    wr(5'b00010, 32'h08); cycle("R3");
    chk(rd_data, 32'h0, "R3");

    for (int i = 0; i < 4000; i++) begin
      in_ev  = $urandom & $urandom & $urandom;
      out_ev = $urandom & $urandom & $urandom;
      dev_ev = 8'($urandom & $urandom & $urandom);
      rd_addr = 5'($urandom);
      if ($urandom_range(0, 9) < 3)
        wr(5'($urandom), ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom);
      cycle(tag_of(rd_addr));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule